// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between an 8-bit host bus and a bank of three 16-bit interval counters. The host sees four byte-wide locations behind a 2-bit address. Locations 0, 1 and 2 are the data ports of counters 0, 1 and 2. Location 3 takes control words. A control word either sets up a channel or freezes a read snapshot of that channel. Setting up a channel means choosing its counting mode, its BCD flag and which bytes of the 16-bit count the data port moves. Freezing a snapshot is the latch command.

Each channel has two byte-order flip-flops, one for writes and one for reads. They turn pairs of 8-bit accesses into whole 16-bit values. On a write, a channel's new initial count goes out with a one-cycle load pulse once the count is complete. On a read, the channel's value comes from the latched snapshot if one is pending, and from the counter's live value otherwise. The snapshot is held until the host has read it in full, so the counter keeps running undisturbed. The counters themselves are outside this block: their current values come in on `ch_value`.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel has mode 0, BCD flag 0 and initial count 0, with no load or control pulse. Every channel starts in two-byte access (low byte first), with no snapshot held.
- R2: A write to address 3 whose access field (bits 5:4) is not 00 sets up one channel. Bits 7:6 choose the channel: 00, 01 or 10 for channels 0, 1 or 2. The channel takes its mode from bits 3:1 and its BCD flag from bit 0. On the next cycle its `ch_mode` and `ch_bcd` hold the new values, and `ch_ctl` pulses for one cycle.
- R3: A control word with bits 7:6 equal to 11 changes no channel and produces no pulse.
- R4: With access 01 (low byte only), a data-port write sets the initial count to {8'h00, byte} and pulses `ch_load` one cycle later.
- R5: With access 10 (high byte only), a data-port write sets the initial count to {byte, 8'h00} and pulses `ch_load` one cycle later.
- R6: With access 11, the first data-port write is held as the low byte and nothing is delivered. The second write supplies the high byte, delivers {high, low} and produces a single `ch_load` pulse.
- R7: A set-up control word (access not 00) returns both byte-order flip-flops of that channel to the low byte, and drops any pending snapshot.
- R8: A control word with access 00 is a latch command. It captures the channel's `ch_value` on that clock edge, and reads then return the captured value while the counter moves on. The command changes neither the mode, the BCD flag, the access setting, nor the initial count, and produces no load pulse.
- R9: A latch command for a channel that already holds a snapshot is ignored, and the first snapshot is kept.
- R10: A snapshot is released once read in full: after one read with access 01 or 10, or after the high-byte read with access 11. Reads after that return the live value.
- R11: Without a snapshot, reads return the live value: the low byte for access 01, the high byte for access 10, and alternating low then high for access 11.
- R12: A read of address 3 returns 8'h00 and changes no channel's read order.
- R13: The read and write byte-order flip-flops of a channel are independent: a read between the two halves of a two-byte write follows its own order and does not disturb the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0-2 data ports, 3 control word |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, advances the read byte order |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| ch_value | input | NUM_CH*16 | Live count of each channel, channel 0 in the low bits |
| ch_mode | output | NUM_CH*3 | Programmed mode of each channel |
| ch_bcd | output | NUM_CH | BCD counting flag of each channel |
| ch_count | output | NUM_CH*16 | Initial count of each channel |
| ch_load | output | NUM_CH | One-cycle pulse when a new initial count is delivered |
| ch_ctl | output | NUM_CH | One-cycle pulse when a channel is set up |

## Verification
The bench builds the block with its default of three channels, so that every data port and every selector value, including the ignored 11, is reached. The counter model in the bench can either hold each channel's live value at a chosen pattern or let it count down every cycle. The held values make byte order and snapshot release exact to predict. The running values show that a snapshot stays still while the live value moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 2'd3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctlw_t;

  // Byte presented on the data port for a given access setting.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                 input acc_e acc,
                                                 input logic hi_next);
    logic [BYTE_W-1:0] r;
    case (acc)
      ACC_HI:   r = v[CNT_W-1:BYTE_W];
      ACC_BOTH: r = hi_next ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
      default:  r = v[BYTE_W-1:0];
    endcase
    return r;
  endfunction

  // Initial count formed by the completing data write.
  function automatic logic [CNT_W-1:0] merge_count(input acc_e acc,
                                                  input logic [BYTE_W-1:0] held_lo,
                                                  input logic [BYTE_W-1:0] b);
    logic [CNT_W-1:0] r;
    case (acc)
      ACC_HI:   r = {b, {BYTE_W{1'b0}}};
      ACC_BOTH: r = {b, held_lo};
      default:  r = {{BYTE_W{1'b0}}, b};
    endcase
    return r;
  endfunction

  // True when this read finishes a full value under the access setting.
  function automatic logic read_completes(input acc_e acc, input logic hi_next);
    return (acc != ACC_BOTH) || hi_next;
  endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wdata,
  output ctlw_t                 cw,
  output logic [NUM_CH-1:0]     prog_evt,
  output logic [NUM_CH-1:0]     latch_evt,
  output logic [NUM_CH-1:0]     dwr_evt,
  output logic [NUM_CH-1:0]     drd_evt
);
  logic ctl_wr;

  always_comb begin
    cw     = ctlw_t'(wdata);
    ctl_wr = wr_en && (addr == CTL_ADDR);
    for (int i = 0; i < NUM_CH; i++) begin
      prog_evt[i]  = ctl_wr && (cw.sel == SEL_W'(i)) && (cw.acc != ACC_LATCH);
      latch_evt[i] = ctl_wr && (cw.sel == SEL_W'(i)) && (cw.acc == ACC_LATCH);
      dwr_evt[i]   = wr_en && (addr == ADDR_W'(i));
      drd_evt[i]   = rd_en && (addr == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlw_t              cw,
  input  logic               prog_evt,
  input  logic               latch_evt,
  input  logic               dwr_evt,
  input  logic               drd_evt,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   live,
  output logic [MODE_W-1:0]  mode,
  output logic               bcd,
  output logic [CNT_W-1:0]   count,
  output logic               load,
  output logic               ctl_pulse,
  output acc_e               acc,
  output logic               latched,
  output logic [CNT_W-1:0]   snap,
  output logic [BYTE_W-1:0]  rd_byte
);
  logic              wr_hi_next;
  logic              rd_hi_next;
  logic [BYTE_W-1:0] held_lo;
  logic              wr_done;
  logic              rd_release;
  logic              snap_take;

  // Named events used by the register process and visible to assertions.
  assign wr_done    = dwr_evt && ((acc != ACC_BOTH) || wr_hi_next);
  assign rd_release = drd_evt && latched && read_completes(acc, rd_hi_next);
  assign snap_take  = latch_evt && !latched;
  assign rd_byte    = pick_byte(latched ? snap : live, acc, rd_hi_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      bcd        <= 1'b0;
      acc        <= ACC_BOTH;
      count      <= '0;
      load       <= 1'b0;
      ctl_pulse  <= 1'b0;
      wr_hi_next <= 1'b0;
      rd_hi_next <= 1'b0;
      held_lo    <= '0;
      latched    <= 1'b0;
      snap       <= '0;
    end else begin
      load      <= 1'b0;
      ctl_pulse <= 1'b0;
      if (prog_evt) begin
        mode       <= cw.mode;
        bcd        <= cw.bcd;
        acc        <= cw.acc;
        wr_hi_next <= 1'b0;
        rd_hi_next <= 1'b0;
        latched    <= 1'b0;
        ctl_pulse  <= 1'b1;
      end else if (snap_take) begin
        latched <= 1'b1;
        snap    <= live;
      end
      if (dwr_evt) begin
        if (wr_done) begin
          count      <= merge_count(acc, held_lo, wdata);
          load       <= 1'b1;
          wr_hi_next <= 1'b0;
        end else begin
          held_lo    <= wdata;
          wr_hi_next <= 1'b1;
        end
      end
      if (drd_evt) begin
        if (acc == ACC_BOTH) rd_hi_next <= !rd_hi_next;
        if (rd_release) latched <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] bytes,
  output logic [BYTE_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = bytes[i];
    end
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic                       wr_en,
  input  logic                       rd_en,
  output logic [BYTE_W-1:0]          rdata,
  input  logic [NUM_CH*CNT_W-1:0]    ch_value,
  output logic [NUM_CH*MODE_W-1:0]   ch_mode,
  output logic [NUM_CH-1:0]          ch_bcd,
  output logic [NUM_CH*CNT_W-1:0]    ch_count,
  output logic [NUM_CH-1:0]          ch_load,
  output logic [NUM_CH-1:0]          ch_ctl
);
  ctlw_t                        cw;
  logic [NUM_CH-1:0]            prog_evt;
  logic [NUM_CH-1:0]            latch_evt;
  logic [NUM_CH-1:0]            dwr_evt;
  logic [NUM_CH-1:0]            drd_evt;
  logic [NUM_CH-1:0][1:0]       acc_q;
  logic [NUM_CH-1:0]            latched_q;
  logic [NUM_CH-1:0][CNT_W-1:0] snap_q;
  logic [NUM_CH-1:0][BYTE_W-1:0] rd_bytes;

  tmr_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cw        (cw),
    .prog_evt  (prog_evt),
    .latch_evt (latch_evt),
    .dwr_evt   (dwr_evt),
    .drd_evt   (drd_evt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    acc_e acc_l;
    tmr_chan_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cw        (cw),
      .prog_evt  (prog_evt[g]),
      .latch_evt (latch_evt[g]),
      .dwr_evt   (dwr_evt[g]),
      .drd_evt   (drd_evt[g]),
      .wdata     (wdata),
      .live      (ch_value[g*CNT_W +: CNT_W]),
      .mode      (ch_mode[g*MODE_W +: MODE_W]),
      .bcd       (ch_bcd[g]),
      .count     (ch_count[g*CNT_W +: CNT_W]),
      .load      (ch_load[g]),
      .ctl_pulse (ch_ctl[g]),
      .acc       (acc_l),
      .latched   (latched_q[g]),
      .snap      (snap_q[g]),
      .rd_byte   (rd_bytes[g])
    );
    assign acc_q[g] = acc_l;
  end

  tmr_rd_mux #(.NUM_CH(NUM_CH)) u_rmux (
    .addr  (addr),
    .bytes (rd_bytes),
    .rdata (rdata)
  );
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            addr,
  input logic [BYTE_W-1:0]            wdata,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [BYTE_W-1:0]            rdata,
  input logic [NUM_CH*MODE_W-1:0]     ch_mode,
  input logic [NUM_CH-1:0]            ch_bcd,
  input logic [NUM_CH*CNT_W-1:0]      ch_count,
  input logic [NUM_CH-1:0]            ch_load,
  input logic [NUM_CH-1:0]            ch_ctl,
  input logic [NUM_CH-1:0][1:0]       acc_q,
  input logic [NUM_CH-1:0]            latched_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] snap_q
);
  // R12
  ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CTL_ADDR) |-> rdata == '0);

  // R3
  sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTL_ADDR && wdata[7:6] == 2'b11) |=> (ch_ctl == '0) && $stable(ch_mode));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    ctl_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CTL_ADDR && wdata[7:6] == SEL_W'(i) && wdata[5:4] != 2'b00)
      |=> ch_ctl[i] && ch_mode[i*MODE_W +: MODE_W] == $past(wdata[3:1])
          && ch_bcd[i] == $past(wdata[0]));

    // R6
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> $past(wr_en) && $past(addr) == ADDR_W'(i));

    // R4
    lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && acc_q[i] == 2'b01) |-> ch_count[i*CNT_W+BYTE_W +: BYTE_W] == '0);

    // R5
    hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && acc_q[i] == 2'b10) |-> ch_count[i*CNT_W +: BYTE_W] == '0);

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_q[i] && $past(latched_q[i])) |-> $stable(snap_q[i]));

    // R8
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CTL_ADDR && wdata[7:6] == SEL_W'(i) && wdata[5:4] == 2'b00)
      |=> $stable(ch_mode[i*MODE_W +: MODE_W]) && $stable(acc_q[i]) && !ch_load[i]);
  end
endmodule

bind tmr_host_if tmr_host_if_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wdata     (wdata),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rdata     (rdata),
  .ch_mode   (ch_mode),
  .ch_bcd    (ch_bcd),
  .ch_count  (ch_count),
  .ch_load   (ch_load),
  .ch_ctl    (ch_ctl),
  .acc_q     (acc_q),
  .latched_q (latched_q),
  .snap_q    (snap_q)
);

// File: tb/test_tmr_host_if.sv
`timescale 1ns/1ps
module test_tmr_host_if;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [7:0]        rdata;
  logic [NCH*16-1:0] ch_value;
  logic [NCH*3-1:0]  ch_mode;
  logic [NCH-1:0]    ch_bcd;
  logic [NCH*16-1:0] ch_count;
  logic [NCH-1:0]    ch_load;
  logic [NCH-1:0]    ch_ctl;

  logic [15:0] cval [NCH];
  logic        run = 1'b0;
  int          nload [NCH];
  int          nctl  [NCH];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_host_if #(.NUM_CH(NCH)) i_tmr_host_if (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .ch_value(ch_value), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .ch_count(ch_count), .ch_load(ch_load), .ch_ctl(ch_ctl)
  );

  // Counter channel model: holds or counts down.
  always @(posedge clk) begin
    if (run) for (int i = 0; i < NCH; i++) cval[i] <= cval[i] - 16'd1;
  end
  always_comb for (int i = 0; i < NCH; i++) ch_value[i*16 +: 16] = cval[i];

  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (ch_load[i]) nload[i]++;
      if (ch_ctl[i])  nctl[i]++;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [2:0] mode_of(input int c);
    return ch_mode[c*3 +: 3];
  endfunction
  function automatic logic [15:0] count_of(input int c);
    return ch_count[c*16 +: 16];
  endfunction

  task automatic t_reset;
    logic [7:0] b;
    chk("R1 mode", {23'd0, ch_mode}, 32'd0);
    chk("R1 bcd", {29'd0, ch_bcd}, 32'd0);
    chk("R1 count", ch_count[31:0], 32'd0);
    chk("R1 pulses", {ch_load, ch_ctl}, 32'd0);
    cval[0] = 16'hA1B2;
    rd(2'd0, b); chk("R1 default low first", b, 8'hB2);
    rd(2'd0, b); chk("R1 default then high", b, 8'hA1);
  endtask

  task automatic t_ctl_decode_r2;
    int c0, c1, c2;
    c0 = nctl[0]; c1 = nctl[1]; c2 = nctl[2];
    wr(2'd3, 8'h77);  // ch1, both bytes, mode 3, bcd
    idle(2);
    chk("R2 ch1 mode", mode_of(1), 3'd3);
    chk("R2 ch1 bcd", ch_bcd[1], 1'b1);
    chk("R2 ch0 mode untouched", mode_of(0), 3'd0);
    chk("R2 ctl pulses", {nctl[0] - c0, nctl[1] - c1, nctl[2] - c2}, {32'd0, 32'd1, 32'd0});
  endtask

  task automatic t_sel3_r3;
    int s;
    logic [8:0] m;
    s = nctl[0] + nctl[1] + nctl[2];
    m = ch_mode;
    wr(2'd3, 8'hFB);
    idle(2);
    chk("R3 modes unchanged", {23'd0, ch_mode}, {23'd0, m});
    chk("R3 bcd unchanged", {29'd0, ch_bcd}, 32'd2);
    chk("R3 no ctl pulse", nctl[0] + nctl[1] + nctl[2], s);
  endtask

  task automatic t_lo_only_r4;
    int n;
    wr(2'd3, 8'h94);  // ch2, low only, mode 2
    n = nload[2];
    wr(2'd2, 8'h5A);
    idle(2);
    chk("R4 count", count_of(2), 16'h005A);
    chk("R4 one load", nload[2] - n, 1);
  endtask

  task automatic t_hi_only_r5;
    int n;
    wr(2'd3, 8'hA8);  // ch2, high only, mode 4
    n = nload[2];
    wr(2'd2, 8'hC3);
    idle(2);
    chk("R5 count", count_of(2), 16'hC300);
    chk("R5 mode", mode_of(2), 3'd4);
    chk("R5 one load", nload[2] - n, 1);
  endtask

  task automatic t_two_byte_r6;
    int n;
    wr(2'd3, 8'h30);  // ch0, both bytes, mode 0
    n = nload[0];
    wr(2'd0, 8'h34);
    idle(2);
    chk("R6 no load after low", nload[0] - n, 0);
    chk("R6 count held", count_of(0), 16'h0000);
    wr(2'd0, 8'h12);
    idle(2);
    chk("R6 count", count_of(0), 16'h1234);
    chk("R6 one load", nload[0] - n, 1);
  endtask

  task automatic t_ff_reset_r7;
    logic [7:0] b;
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h99);  // low byte pending
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h22);
    idle(2);
    chk("R7 write order restarted", count_of(0), 16'h2211);
    cval[0] = 16'h1357;
    wr(2'd3, 8'h00);  // latch ch0
    cval[0] = 16'h2468;
    rd(2'd0, b);      // read order now on high byte
    wr(2'd3, 8'h30);
    rd(2'd0, b); chk("R7 latch dropped, low", b, 8'h68);
    rd(2'd0, b); chk("R7 latch dropped, high", b, 8'h24);
  endtask

  task automatic t_latch_r8;
    logic [15:0] v;
    logic [7:0]  lo, hi;
    logic [15:0] cnt;
    int n;
    wr(2'd3, 8'h76);  // ch1, both bytes, mode 3
    cnt = count_of(1);
    n = nload[1];
    run = 1'b1;
    idle(3);
    @(negedge clk);
    addr = 2'd3; wdata = 8'h4F; wr_en = 1'b1;  // latch ch1, low bits set
    v = cval[1];
    @(negedge clk);
    wr_en = 1'b0;
    idle(7);
    rd(2'd1, lo);
    idle(4);
    rd(2'd1, hi);
    run = 1'b0;
    idle(2);
    chk("R8 snapshot value", {hi, lo}, v);
    chk("R8 counter moved on", (cval[1] != v), 1'b1);
    chk("R8 mode kept", mode_of(1), 3'd3);
    chk("R8 count kept", count_of(1), cnt);
    chk("R8 no load", nload[1] - n, 0);
  endtask

  task automatic t_double_latch_r9;
    logic [7:0] lo, hi;
    wr(2'd3, 8'h76);
    cval[1] = 16'h1111;
    wr(2'd3, 8'h40);
    cval[1] = 16'h2222;
    wr(2'd3, 8'h40);
    cval[1] = 16'h3333;
    rd(2'd1, lo);
    rd(2'd1, hi);
    chk("R9 first snapshot kept", {hi, lo}, 16'h1111);
  endtask

  task automatic t_release_r10;
    logic [7:0] b;
    wr(2'd3, 8'h90);  // ch2, low only
    cval[2] = 16'h00AA;
    wr(2'd3, 8'h80);
    cval[2] = 16'h00BB;
    rd(2'd2, b); chk("R10 low-only snapshot", b, 8'hAA);
    rd(2'd2, b); chk("R10 low-only released", b, 8'hBB);
    wr(2'd3, 8'h76);
    cval[1] = 16'h1111;
    wr(2'd3, 8'h40);
    cval[1] = 16'h2222;
    rd(2'd1, b); chk("R10 two-byte low from snapshot", b, 8'h11);
    rd(2'd1, b); chk("R10 two-byte high from snapshot", b, 8'h11);
    rd(2'd1, b); chk("R10 two-byte released", b, 8'h22);
  endtask

  task automatic t_live_r11;
    logic [7:0] b;
    wr(2'd3, 8'h76);
    cval[1] = 16'hABCD;
    rd(2'd1, b); chk("R11 live low", b, 8'hCD);
    rd(2'd1, b); chk("R11 live high", b, 8'hAB);
    rd(2'd1, b); chk("R11 live low again", b, 8'hCD);
    wr(2'd3, 8'hA8);
    cval[2] = 16'h5AC3;
    rd(2'd2, b); chk("R11 high-only", b, 8'h5A);
    rd(2'd2, b); chk("R11 high-only repeat", b, 8'h5A);
  endtask

  task automatic t_ctl_read_r12;
    logic [7:0] b;
    wr(2'd3, 8'h76);
    cval[1] = 16'h6789;
    rd(2'd1, b);
    rd(2'd3, b); chk("R12 control read zero", b, 8'h00);
    rd(2'd1, b); chk("R12 order untouched", b, 8'h67);
  endtask

  task automatic t_interleave_r13;
    logic [7:0] b;
    wr(2'd3, 8'h30);
    cval[0] = 16'hBEEF;
    wr(2'd0, 8'h34);
    rd(2'd0, b); chk("R13 read low during write", b, 8'hEF);
    wr(2'd0, 8'h12);
    idle(2);
    chk("R13 write intact", count_of(0), 16'h1234);
    rd(2'd0, b); chk("R13 read high", b, 8'hBE);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      cval[i] = '0; nload[i] = 0; nctl[i] = 0;
    end
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_ctl_decode_r2;
    t_sel3_r3;
    t_lo_only_r4;
    t_hi_only_r5;
    t_two_byte_r6;
    t_ff_reset_r7;
    t_latch_r8;
    t_double_latch_r9;
    t_release_r10;
    t_live_r11;
    t_ctl_read_r12;
    t_interleave_r13;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule